// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides an unsigned N-bit dividend by an unsigned N-bit divisor over several clock cycles and returns an N-bit quotient, an N-bit remainder and a flag that marks a zero divisor. A one-cycle start pulse captures both operands. The block then settles one quotient bit per clock. It uses a single adder/subtractor one bit wider than the operands. When the operation is complete, done rises for one cycle.

The working state is one shifting register. Its upper N+1 bits hold the signed partial remainder and its lower N bits start as the dividend and fill up with quotient bits. On every step the register shifts left by one place. The sign of the partial remainder before the shift then decides what happens to the upper part: the divisor is subtracted when that sign is non-negative and added when it is negative. A failed trial is therefore never undone in a cycle of its own. The new quotient bit is the inverse of the sign of the result. After the last step, one correction cycle adds the divisor back if the remainder is negative.

A zero divisor is detected when start is sampled. In that case no iteration takes place: the quotient is all ones, the remainder is the dividend, and done follows in the next cycle.

Top module: `seq_nr_divider`

## Requirements
- R1: With a non-zero divisor, done is high in the cycle that follows the (N+1)-th rising clock edge after the edge that sampled start: N step cycles and one correction cycle.
- R2: For a non-zero divisor, when done is high the quotient equals floor(dividend/divisor) and the remainder equals dividend mod divisor, so the remainder is always below the divisor.
- R3: With a zero divisor, done is high in the cycle right after the edge that sampled start, the quotient is all ones, the remainder equals the dividend and div_by_zero is 1.
- R4: With a non-zero divisor, div_by_zero is 0 when done is high.
- R5: done is high for exactly one cycle per accepted operation.
- R6: A start pulse that arrives while an operation is in progress has no effect: the running result and its done timing are unchanged.
- R7: The quotient, remainder and div_by_zero hold their values from done until the next accepted start.
- R8: After a synchronous active-low reset, done, div_by_zero, quotient and remainder are all 0.
- R9: With N=5, dividend 7 and divisor 2 give quotient 3 and remainder 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request; sampled only while idle |
| dividend | input | N | Unsigned dividend, captured with start |
| divisor | input | N | Unsigned divisor, captured with start |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |
| div_by_zero | output | 1 | Set when the captured divisor was zero |

## Verification
The bench uses N=5 and runs every dividend and divisor pair, including every dividend over a zero divisor. This catches a missing final correction, which would return a wrapped negative remainder on most pairs. A dividend smaller than the divisor must return quotient 0 and the dividend as remainder; a quotient bit taken with the wrong polarity fails on these. Division by 1 must return the full-scale value; a quotient bit lost from the shift chain fails on this. Some runs get a second start pulse with different operands in the middle of the operation, to catch a design that restarts. Every operation also measures when done rises, so that an extra step, a skipped step or a done pulse that lasts two cycles shows up as a wrong cycle count.

// File: rtl/nrdiv_pkg.sv
// Package: shared types for the sequential non-restoring divider.
// Assumes nothing beyond IEEE 1800-2017.
package nrdiv_pkg;

    // Sequencer phases: waiting, iterating, final sign correction
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_STEP = 2'd1,
        PH_FIX  = 2'd2
    } div_phase_e;

endpackage

// File: rtl/nrdiv_addsub.sv
// Module: nrdiv_addsub
// Ripple add/subtract unit of W bits. When sub is 1 it returns a - b
// (by inverting b and forcing a carry in); otherwise it returns a + b.
// The carry out is dropped, because the caller works modulo 2^W.
module nrdiv_addsub #(
    parameter int W = 9
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    logic [W-1:0] b_eff;
    logic [W:0]   cy;

    // Operand inversion for subtraction
    always_comb b_eff = b ^ {W{sub}};

    assign cy[0] = sub;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            // One full-adder slice
            assign y[i]    = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
        end
    endgenerate
endmodule

// File: rtl/nrdiv_ctrl.sv
// Module: nrdiv_ctrl
// Sequencer for the divider. It accepts start only while idle. It then
// runs N step cycles followed by one correction cycle and raises done
// for one cycle. A zero divisor skips the iteration and finishes in one
// cycle. Assumes N >= 2.
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       div_zero,
    output div_phase_e phase,
    output logic       load_run,
    output logic       load_zero,
    output logic       step,
    output logic       fix,
    output logic       done,
    output logic       dz
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    logic [CW-1:0] cnt;

    // Decode the datapath strobes from the phase
    always_comb begin
        load_run  = (phase == PH_IDLE) && start && !div_zero;
        load_zero = (phase == PH_IDLE) && start && div_zero;
        step      = (phase == PH_STEP);
        fix       = (phase == PH_FIX);
    end

    // Phase register, step counter, done pulse and zero-divisor flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
            dz    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (load_run) begin
                        phase <= PH_STEP;
                        cnt   <= '0;
                        dz    <= 1'b0;
                    end else if (load_zero) begin
                        done <= 1'b1;
                        dz   <= 1'b1;
                    end
                end
                PH_STEP: begin
                    if (cnt == LAST) phase <= PH_FIX;
                    else             cnt   <= cnt + 1'b1;
                end
                PH_FIX: begin
                    phase <= PH_IDLE;
                    done  <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R1: the counter advances by one in every step cycle before the last
    a_r1_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STEP && cnt != LAST) |=> (phase == PH_STEP && cnt == $past(cnt) + 1'b1));

    // R1: the correction cycle is followed by done and a return to idle
    a_r1_fix_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIX) |=> (done && phase == PH_IDLE));

    // R5: done never lasts two cycles
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: start is not accepted while busy
    a_r6_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STEP && start) |=> (phase != PH_IDLE));
endmodule

// File: rtl/nrdiv_core.sv
// Module: nrdiv_core
// Datapath. It holds the (N+1)-bit signed partial remainder and the
// N-bit quotient/dividend as one shifting pair, plus the captured
// divisor. Each step shifts the pair left and then adds or subtracts
// the divisor in the upper part only. Assumes at most one strobe per
// cycle and N >= 2.
module nrdiv_core #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_run,
    input  logic         load_zero,
    input  logic         step,
    input  logic         fix,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic [N-1:0] quot,
    output logic [N-1:0] rem,
    output logic [N-1:0] div_held,
    output logic         rem_neg
);
    localparam int PW = N + 1;

    logic [PW-1:0] part;
    logic [N-1:0]  qreg;
    logic [N-1:0]  dreg;
    logic [PW-1:0] shifted;
    logic [PW-1:0] op_a;
    logic          op_sub;
    logic [PW-1:0] result;

    // Shifted partial remainder and operand selection for the single adder
    always_comb begin
        shifted = {part[PW-2:0], qreg[N-1]};
        op_a    = fix ? part : shifted;
        op_sub  = fix ? 1'b0 : !part[PW-1];
    end

    nrdiv_addsub #(.W(PW)) u_alu (
        .a   (op_a),
        .b   ({1'b0, dreg}),
        .sub (op_sub),
        .y   (result)
    );

    // Register update: load, iterate or correct
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            part <= '0;
            qreg <= '0;
            dreg <= '0;
        end else if (load_run) begin
            part <= '0;
            qreg <= dividend;
            dreg <= divisor;
        end else if (load_zero) begin
            part <= {1'b0, dividend};
            qreg <= '1;
            dreg <= divisor;
        end else if (step) begin
            part <= result;
            qreg <= {qreg[N-2:0], !result[PW-1]};
        end else if (fix && part[PW-1]) begin
            part <= result;
        end
    end

    always_comb begin
        quot     = qreg;
        rem      = part[N-1:0];
        div_held = dreg;
        rem_neg  = part[PW-1];
    end

    // R2: after the correction cycle the partial remainder is non-negative
    a_r2_fix_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        fix |=> !part[PW-1]);

    // R2: a negative partial remainder is never followed by a subtraction
    a_r2_add_after_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (step && part[PW-1]) |-> !op_sub);
endmodule

// File: rtl/seq_nr_divider.sv
// Module: seq_nr_divider
// Top of the sequential non-restoring unsigned divider. It ties the
// sequencer to the datapath. Operands are sampled on a start pulse
// while idle, and results stay valid from done until the next start.
// Assumes N >= 2.
module seq_nr_divider
    import nrdiv_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         done,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder,
    output logic         div_by_zero
);
    div_phase_e   phase;
    logic         load_run, load_zero, step, fix;
    logic [N-1:0] div_held;
    logic         rem_neg;
    logic         div_zero;

    // Zero-divisor detection on the live operand
    always_comb div_zero = (divisor == '0);

    nrdiv_ctrl #(.N(N)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .div_zero  (div_zero),
        .phase     (phase),
        .load_run  (load_run),
        .load_zero (load_zero),
        .step      (step),
        .fix       (fix),
        .done      (done),
        .dz        (div_by_zero)
    );

    nrdiv_core #(.N(N)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_run  (load_run),
        .load_zero (load_zero),
        .step      (step),
        .fix       (fix),
        .dividend  (dividend),
        .divisor   (divisor),
        .quot      (quotient),
        .rem       (remainder),
        .div_held  (div_held),
        .rem_neg   (rem_neg)
    );

    // R2: a finished non-zero division leaves the remainder below the divisor
    a_r2_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !div_by_zero) |-> (remainder < div_held));

    // R2: the partial remainder is never negative while idle
    a_r2_idle_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !rem_neg);

    // R3: a zero divisor returns an all-ones quotient
    a_r3_zero_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_by_zero) |-> (quotient == '1));

    // R7: results hold while idle without a start
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

// File: tb/sim_seq_nr_divider.sv
`timescale 1ns/1ps
// Bench: exhaustive sweep of all operand pairs at N=5, plus operations
// that receive a second start while busy.
module sim_seq_nr_divider;
    localparam int W = 5;
    localparam int WD_LIMIT = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_by_zero;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    seq_nr_divider #(.N(W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_by_zero (div_by_zero)
    );

    // Watchdog: ends a hung run as a failure
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT) begin
            fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles, expected below %0d", cycles, WD_LIMIT);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int got, input int exp);
        tests = tests + 1;
        if (got != exp) begin
            fails = fails + 1;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // One division; when intr is set, a second start arrives mid-run
    task automatic run_div(input int a, input int b, input bit intr);
        int cyc;
        int exp_q, exp_r, exp_lat;
        @(negedge clk);
        dividend = W'(a);
        divisor  = W'(b);
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 100) begin
            if (intr && cyc == 1) begin
                start    = 1'b1;
                dividend = W'(a ^ 5'h15);
                divisor  = W'(b == 0 ? 1 : (b % 7) + 1);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc = cyc + 1;
        end
        start = 1'b0;
        if (b == 0) begin
            exp_q = (1 << W) - 1; exp_r = a; exp_lat = 0;
            check("R3 latency", cyc, exp_lat);
            check("R3 quotient", int'(quotient), exp_q);
            check("R3 remainder", int'(remainder), exp_r);
            check("R3 flag", int'(div_by_zero), 1);
        end else begin
            exp_q = a / b; exp_r = a % b; exp_lat = W + 1;
            if (intr) begin
                check("R6 latency", cyc, exp_lat);
                check("R6 quotient", int'(quotient), exp_q);
                check("R6 remainder", int'(remainder), exp_r);
            end else begin
                check("R1 latency", cyc, exp_lat);
                check("R2 quotient", int'(quotient), exp_q);
                check("R2 remainder", int'(remainder), exp_r);
            end
            check("R4 flag", int'(div_by_zero), 0);
        end
        @(negedge clk);
        check("R5 done width", int'(done), 0);
        check("R7 quotient hold", int'(quotient), exp_q);
        check("R7 remainder hold", int'(remainder), exp_r);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 done", int'(done), 0);
        check("R8 flag", int'(div_by_zero), 0);
        check("R8 quotient", int'(quotient), 0);
        check("R8 remainder", int'(remainder), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: worked example 7 / 2
        run_div(7, 2, 1'b0);
        check("R9 quotient", int'(quotient), 3);
        check("R9 remainder", int'(remainder), 1);

        // R2, R3: exhaustive sweep
        for (int a = 0; a < (1 << W); a++)
            for (int b = 0; b < (1 << W); b++)
                run_div(a, b, 1'b0);

        // R6: start pulses during a running operation
        for (int k = 0; k < 40; k++)
            run_div((k * 7 + 3) % (1 << W), (k % 9) + 1, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule